// File: doc/BRIEF.md
# Microprogram Sequencer Core

This block is the execution engine of a small microprogrammed controller. A program counter addresses a fixed combinational program store. Each word holds an opcode, a one-hot "last cycle" field and an argument byte that doubles as a jump target. A one-hot cycle counter walks through the clocks of the current instruction. Registered per-cycle strobes are decoded for the user opcodes and feed one driver group, which updates an output byte.

Run control comes from a separate start/stop controller. It supplies a begin-load strobe, an end-load strobe and a start-hold strobe; the start-hold strobe is the delayed second clock of a begin request. The program counter is updated from a four-input priority vector. A jump is taken only when cycle bit 0 was observed one clock earlier, so that each jump instruction loads its target exactly once. The built-in program is a short test routine. It contains a three-cycle transfer, a one-cycle mix, two conditional jumps and an end address that jumps to itself.

Top module: `useq_core`

## Requirements
- R1: While reset is high, the program counter is all ones (15), the cycle counter is 0, every strobe is 0, the driver byte is 0x00 and the driver idle flag is 1.
- R2: A cycle counter at zero reloads to 0001 two clocks later through a registered zero detect. From reset with all control inputs low, the counter reads 0, 0001, 0001 after the first three clocks, and the program counter moves from 15 to 0 on the fourth clock.
- R3: The program counter update is prioritised as follows: begin-load sets 0, then end-load sets 7, then a taken jump loads the argument's low four bits, then a registered increment adds one.
- R4: The 4-bit cycle counter is one-hot or zero. It reloads to 0001 on increment, taken jump, start-hold or zero detect; otherwise it shifts left by one with bit 0 cleared.
- R5: An instruction whose last-cycle field has bit N set occupies N+2 clocks in steady state. The increment strobe is registered from a match of the counter with the field and is blocked by start-hold.
- R6: An unconditional jump loads its target two clocks after it is entered, and only once.
- R7: Opcode 4 jumps only when cond_i[0] is 1, and opcode 5 jumps only when cond_i[1] is 1. Otherwise each falls through to the next address.
- R8: Strobe bits 0 to 2 rise one clock after cycle bits 0 to 2 while the opcode is the transfer (2). Bit 3 rises one clock after cycle bit 0 while the opcode is the mix (3).
- R9: One clock after a single strobe, the driver acts as follows: bit 0 loads the argument, bit 1 shifts left by one, bit 2 adds one, bit 3 XORs the argument. Each of these clears the idle flag. An all-zero strobe vector sets the idle flag and holds the byte.
- R10: With start-hold high, the cycle counter is 0001 on the next clock and no increment follows from that clock.
- R11: Address 7 is a jump to itself, so the program counter stays at 7 once it is reached.
- R12: The opcode codes are nop 0, jump 1, transfer 2, mix 3, jump-if-cond0 4 and jump-if-cond1 5. The program is: 0 transfer 0x21, 1 mix 0x0F, 2 jump-if-cond0 to 5, 3 nop, 4 jump to 6, 5 mix 0x50, 6 jump-if-cond1 to 0, 7 jump to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_begin_i | input | 1 | Load the begin address (highest priority) |
| ld_end_i | input | 1 | Load the end address |
| start_hold_i | input | 1 | Delayed start strobe: reloads the cycle counter and blocks increment |
| cond_i | input | 2 | Condition inputs for the conditional jumps |
| pc_o | output | 4 | Program counter |
| opcode_o | output | 3 | Opcode of the current program word |
| cycle_o | output | 4 | One-hot cycle counter |
| strobe_o | output | 4 | Registered per-cycle strobes |
| drv_val_o | output | 8 | Driver group output byte |
| drv_idle_o | output | 1 | Driver default-action flag |

## Verification
The zero-detect recovery path is the hardest state to reach. It only fires when the cycle counter is empty, and in normal running it never is. The bench therefore releases reset and leaves every control input low, so the empty counter left by reset has to be repaired by the registered detect alone. Cycle by cycle, the bench follows the counter and the program counter's wrap from 15 to 0. The startup sequence is also checked against a cycle-exact table. In that sequence, the reload from start-hold and the reload from zero detect land on consecutive clocks, and the first transfer strobe fires twice.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int OP_W     = 3;
    localparam int CYC_W    = 3;
    localparam int CNT_W    = CYC_W + 1;
    localparam int N_COND   = 2;
    localparam int XFER_CYC = 3;
    localparam int N_STB    = XFER_CYC + 1;

    localparam logic [ADDR_W-1:0] BEGIN_PC = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] END_PC   = ADDR_W'(7);

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 3'd0,
        OP_JUMP = 3'd1,
        OP_XFER = 3'd2,
        OP_MIX  = 3'd3,
        OP_JC0  = 3'd4,
        OP_JC1  = 3'd5
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [CYC_W-1:0]  last;
        logic [DATA_W-1:0] arg;
    } uword_t;

    function automatic int unsigned last_index(op_e op);
        return (op == OP_XFER) ? XFER_CYC - 1 : 0;
    endfunction

    function automatic uword_t mk_word(op_e op, logic [DATA_W-1:0] arg);
        uword_t w;
        w.op   = op;
        w.last = CYC_W'(1) << last_index(op);
        w.arg  = arg;
        return w;
    endfunction

    function automatic uword_t prog_word(logic [ADDR_W-1:0] a);
        case (a)
            ADDR_W'(0): return mk_word(OP_XFER, DATA_W'(8'h21));
            ADDR_W'(1): return mk_word(OP_MIX,  DATA_W'(8'h0F));
            ADDR_W'(2): return mk_word(OP_JC0,  DATA_W'(5));
            ADDR_W'(3): return mk_word(OP_NOP,  DATA_W'(0));
            ADDR_W'(4): return mk_word(OP_JUMP, DATA_W'(6));
            ADDR_W'(5): return mk_word(OP_MIX,  DATA_W'(8'h50));
            ADDR_W'(6): return mk_word(OP_JC1,  DATA_W'(0));
            ADDR_W'(7): return mk_word(OP_JUMP, DATA_W'(END_PC));
            default:    return mk_word(OP_NOP,  DATA_W'(0));
        endcase
    endfunction

    function automatic logic wants_jump(op_e op, logic [N_COND-1:0] c);
        case (op)
            OP_JUMP: return 1'b1;
            OP_JC0:  return c[0];
            OP_JC1:  return c[1];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);

    always_comb begin
        word = prog_word(addr);
    end

endmodule

// File: rtl/useq_seq.sv
module useq_seq
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_begin,
    input  logic              ld_end,
    input  logic              hold,
    input  logic [N_COND-1:0] cond,
    input  op_e               op,
    input  logic [CYC_W-1:0]  last,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc,
    output logic [CNT_W-1:0]  cyc
);

    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [CNT_W-1:0]  cyc_q, cyc_d;
    logic              inc_q, jmp_q, bit0_d_q, zero_q;
    logic              take_jump, reload;
    logic [3:0]        upd;

    assign take_jump = jmp_q & bit0_d_q;
    assign upd       = {ld_begin, ld_end, take_jump, inc_q};
    assign reload    = inc_q | take_jump | hold | zero_q;

    always_comb begin
        casez (upd)
            4'b1???: pc_d = BEGIN_PC;
            4'b01??: pc_d = END_PC;
            4'b001?: pc_d = target;
            4'b0001: pc_d = pc_q + ADDR_W'(1);
            default: pc_d = pc_q;
        endcase
    end

    always_comb begin
        if (reload) begin
            cyc_d = CNT_W'(1);
        end else begin
            cyc_d = {cyc_q[CNT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '1;
            cyc_q    <= '0;
            inc_q    <= 1'b0;
            jmp_q    <= 1'b0;
            bit0_d_q <= 1'b0;
            zero_q   <= 1'b0;
        end else begin
            pc_q     <= pc_d;
            cyc_q    <= cyc_d;
            inc_q    <= (cyc_q == {1'b0, last}) && !hold;
            jmp_q    <= wants_jump(op, cond);
            bit0_d_q <= cyc_q[0] && !hold;
            zero_q   <= (cyc_q == '0);
        end
    end

    assign pc  = pc_q;
    assign cyc = cyc_q;

endmodule

// File: rtl/useq_strobe.sv
module useq_strobe
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [CNT_W-1:0] cyc,
    output logic [N_STB-1:0] stb
);

    logic [N_STB-1:0] hit;

    for (genvar k = 0; k < XFER_CYC; k++) begin : g_xfer
        assign hit[k] = (op == OP_XFER) && cyc[k];
    end
    assign hit[N_STB-1] = (op == OP_MIX) && cyc[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stb <= '0;
        end else begin
            stb <= hit;
        end
    end

endmodule

// File: rtl/useq_drv.sv
module useq_drv
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_STB-1:0]  stb,
    input  logic [DATA_W-1:0] arg,
    output logic [DATA_W-1:0] val,
    output logic              idle
);

    localparam logic [N_STB-1:0] SEL_LOAD = N_STB'(1);
    localparam logic [N_STB-1:0] SEL_SHL  = N_STB'(2);
    localparam logic [N_STB-1:0] SEL_INC  = N_STB'(4);
    localparam logic [N_STB-1:0] SEL_MIX  = N_STB'(1) << (N_STB - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            val  <= '0;
            idle <= 1'b1;
        end else begin
            case (stb)
                '0: idle <= 1'b1;
                SEL_LOAD: begin
                    val  <= arg;
                    idle <= 1'b0;
                end
                SEL_SHL: begin
                    val  <= {val[DATA_W-2:0], 1'b0};
                    idle <= 1'b0;
                end
                SEL_INC: begin
                    val  <= val + DATA_W'(1);
                    idle <= 1'b0;
                end
                SEL_MIX: begin
                    val  <= val ^ arg;
                    idle <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_begin_i,
    input  logic              ld_end_i,
    input  logic              start_hold_i,
    input  logic [N_COND-1:0] cond_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [OP_W-1:0]   opcode_o,
    output logic [CNT_W-1:0]  cycle_o,
    output logic [N_STB-1:0]  strobe_o,
    output logic [DATA_W-1:0] drv_val_o,
    output logic              drv_idle_o
);

    uword_t            word;
    logic [ADDR_W-1:0] pc;
    logic [CNT_W-1:0]  cyc;
    logic [N_STB-1:0]  stb;

    useq_store u_store (
        .addr (pc),
        .word (word)
    );

    useq_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .ld_begin (ld_begin_i),
        .ld_end   (ld_end_i),
        .hold     (start_hold_i),
        .cond     (cond_i),
        .op       (word.op),
        .last     (word.last),
        .target   (word.arg[ADDR_W-1:0]),
        .pc       (pc),
        .cyc      (cyc)
    );

    useq_strobe u_strobe (
        .clk (clk),
        .rst (rst),
        .op  (word.op),
        .cyc (cyc),
        .stb (stb)
    );

    useq_drv u_drv (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .arg  (word.arg),
        .val  (drv_val_o),
        .idle (drv_idle_o)
    );

    assign pc_o     = pc;
    assign opcode_o = word.op;
    assign cycle_o  = cyc;
    assign strobe_o = stb;

endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ld_begin_i,
    input logic              ld_end_i,
    input logic              start_hold_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [CNT_W-1:0]  cycle_o,
    input logic [N_STB-1:0]  strobe_o,
    input logic              drv_idle_o
);

    AST_CYC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cycle_o)); // R4

    AST_ZERO_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (cycle_o == '0) |-> ##2 (cycle_o == CNT_W'(1))); // R2

    AST_BEGIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_begin_i |=> (pc_o == BEGIN_PC)); // R3

    AST_END_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ld_end_i && !ld_begin_i) |=> (pc_o == END_PC)); // R3

    AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (rst)
        start_hold_i |=> (cycle_o == CNT_W'(1))); // R10

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o)); // R8

    AST_DEFAULT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (strobe_o == '0) |=> drv_idle_o); // R9

    AST_ACTION_BUSY: assert property (@(posedge clk) disable iff (rst)
        (strobe_o != '0) |=> !drv_idle_o); // R9

endmodule

bind useq_core useq_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ld_begin_i   (ld_begin_i),
    .ld_end_i     (ld_end_i),
    .start_hold_i (start_hold_i),
    .pc_o         (pc_o),
    .cycle_o      (cycle_o),
    .strobe_o     (strobe_o),
    .drv_idle_o   (drv_idle_o)
);

// File: tb/sim_useq_core.sv
module sim_useq_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_begin = 1'b0;
    logic       ld_end = 1'b0;
    logic       hold = 1'b0;
    logic [1:0] cond = 2'b00;
    logic [3:0] pc;
    logic [2:0] opcode;
    logic [3:0] cyc;
    logic [3:0] stb;
    logic [7:0] val;
    logic       idle;

    int n_chk = 0;
    int n_err = 0;
    logic [3:0] traj [8];
    int tlen;

    always #5 clk = ~clk;

    useq_core u0 (
        .clk          (clk),
        .rst          (rst),
        .ld_begin_i   (ld_begin),
        .ld_end_i     (ld_end),
        .start_hold_i (hold),
        .cond_i       (cond),
        .pc_o         (pc),
        .opcode_o     (opcode),
        .cycle_o      (cyc),
        .strobe_o     (stb),
        .drv_val_o    (val),
        .drv_idle_o   (idle)
    );

    // Row: {ld_begin, hold, pc, cycle, strobes, drv_val, drv_idle}, one per clock from reset release
    localparam logic [22:0] TBL [20] = '{
        {1'b1, 1'b0, 4'd0, 4'b0000, 4'b0000, 8'h00, 1'b1},
        {1'b1, 1'b1, 4'd0, 4'b0001, 4'b0000, 8'h00, 1'b1},
        {1'b0, 1'b0, 4'd0, 4'b0001, 4'b0001, 8'h00, 1'b1},
        {1'b0, 1'b0, 4'd0, 4'b0010, 4'b0001, 8'h21, 1'b0},
        {1'b0, 1'b0, 4'd0, 4'b0100, 4'b0010, 8'h21, 1'b0},
        {1'b0, 1'b0, 4'd0, 4'b1000, 4'b0100, 8'h42, 1'b0},
        {1'b0, 1'b0, 4'd1, 4'b0001, 4'b0000, 8'h43, 1'b0},
        {1'b0, 1'b0, 4'd1, 4'b0010, 4'b1000, 8'h43, 1'b1},
        {1'b0, 1'b0, 4'd2, 4'b0001, 4'b0000, 8'h4C, 1'b0},
        {1'b0, 1'b0, 4'd2, 4'b0010, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd3, 4'b0001, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd3, 4'b0010, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd4, 4'b0001, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd4, 4'b0010, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd6, 4'b0001, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd6, 4'b0010, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd7, 4'b0001, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd7, 4'b0010, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd7, 4'b0001, 4'b0000, 8'h4C, 1'b1},
        {1'b0, 1'b0, 4'd7, 4'b0010, 4'b0000, 8'h4C, 1'b1}
    };

    localparam logic [3:0] TRAJ_B [6] = '{4'd0, 4'd1, 4'd2, 4'd5, 4'd6, 4'd7};
    localparam logic [3:0] TRAJ_C [8] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd0, 4'd1};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ld_begin = 1'b0; ld_end = 1'b0; hold = 1'b0; cond = 2'b00;
        repeat (3) tick();
    endtask

    task automatic start_prog();
        ld_begin = 1'b1; hold = 1'b0;
        tick();
        hold = 1'b1;
        tick();
        ld_begin = 1'b0; hold = 1'b0;
    endtask

    task automatic trace(input bit to_end, input int max_len, input int limit);
        logic [3:0] last;
        tlen = 1;
        traj[0] = pc;
        last = pc;
        for (int i = 0; i < limit; i++) begin
            tick();
            if (pc != last) begin
                if (tlen < 8) traj[tlen] = pc;
                tlen++;
                last = pc;
            end
            if (to_end && pc == 4'd7) break;
            if (!to_end && tlen >= max_len) break;
        end
    endtask

    initial begin
        #(10 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset values
        chk("R1 pc", pc, 4'hF);
        chk("R1 cycle", cyc, 4'b0000);
        chk("R1 strobes", stb, 4'b0000);
        chk("R1 drv_val", val, 8'h00);
        chk("R1 drv_idle", idle, 1'b1);

        // R2 empty counter repaired by zero detect alone
        rst = 1'b0;
        tick();
        chk("R2 cycle clk1", cyc, 4'b0000);
        tick();
        chk("R2 cycle clk2", cyc, 4'b0001);
        tick();
        chk("R2 cycle clk3", cyc, 4'b0001);
        chk("R2 pc clk3", pc, 4'hF);
        tick();
        chk("R2 pc wrap clk4", pc, 4'h0);

        // Cycle-exact startup and run with both conditions low
        do_reset();
        rst = 1'b0;
        for (int r = 0; r < 20; r++) begin
            ld_begin = TBL[r][22];
            hold     = TBL[r][21];
            tick();
            chk($sformatf("R5 R6 R7 pc row%0d", r), pc, TBL[r][20:17]);
            chk($sformatf("R4 cycle row%0d", r), cyc, TBL[r][16:13]);
            chk($sformatf("R8 strobes row%0d", r), stb, TBL[r][12:9]);
            chk($sformatf("R9 drv_val row%0d", r), val, TBL[r][8:1]);
            chk($sformatf("R9 drv_idle row%0d", r), idle, TBL[r][0]);
            if (r == 1) chk("R10 hold reload", cyc, 4'b0001);
            if (r == 2) chk("R10 no increment after hold", pc, 4'd0);
        end
        ld_begin = 1'b0; hold = 1'b0;
        chk("R12 opcode at end", opcode, 3'd1);

        // R11 end address holds
        for (int i = 0; i < 10; i++) begin
            tick();
            chk("R11 pc stays at end", pc, 4'd7);
        end

        // Run B: cond0 taken, cond1 falls through
        cond = 2'b01;
        start_prog();
        chk("R12 opcode at begin", opcode, 3'd2);
        trace(1'b1, 8, 300);
        chk("R7 trajectory length B", tlen, 6);
        for (int i = 0; i < 6; i++) chk("R7 trajectory B", traj[i], TRAJ_B[i]);
        chk("R9 drv_val after run B", val, 8'h5C ^ 8'h40);

        // Run C: cond1 loops back to begin
        cond = 2'b10;
        start_prog();
        trace(1'b0, 8, 300);
        chk("R7 trajectory length C", tlen, 8);
        for (int i = 0; i < 8; i++) chk("R6 R7 trajectory C", traj[i], TRAJ_C[i]);

        // R3 priority
        ld_begin = 1'b1; ld_end = 1'b1;
        tick();
        chk("R3 begin over end", pc, 4'd0);
        ld_begin = 1'b0;
        tick();
        chk("R3 end load clk1", pc, 4'd7);
        tick();
        chk("R3 end load clk2", pc, 4'd7);
        ld_end = 1'b0;
        cond = 2'b00;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R11 pc stays at end after end load", pc, 4'd7);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule